// File: doc/BRIEF.md
# Wakeup External Interrupt Controller

This block watches 28 asynchronous wakeup lines and latches a pending flag for each line when that line shows the event it is programmed for: a held low level, a held high level, a falling edge, a rising edge or either edge. The trigger choice is made per pair of adjacent lines, so lines 2k and 2k+1 always follow the same rule. Each line is synchronised by two flops before detection, and an edge is an inequality between the current synchronised sample and the one before it.

Software uses a simple word-addressed register bus with single-cycle writes and a combinational read. Through it, software sets up trigger fields, sets or clears mask bits, and clears pending flags by writing ones. Four parent interrupt outputs reduce the pending-and-unmasked lines over fixed ranges of unequal size, one of four lines and three of eight, so an interrupt controller upstream sees four requests and finds the line by reading the pending register.

Top module: `wkup_eint_ctrl`

## Requirements
- R1: While and right after reset, the mask register reads 0x0FFFFFFF (all 28 lines masked), the pending register reads 0, both trigger registers read 0 and all four parent outputs are low.
- R2: Word address 0 holds the trigger fields for lines 0 to 15 and word address 1 those for lines 16 to 27; line i uses the 4-bit field at bits 4*((i mod 16) div 2)+3 down to 4*((i mod 16) div 2) of register i div 16, so two adjacent lines share one field. Word 1 stores only bits 23:0 and reads 0 in bits 31:24. Word 2 is the mask (bit i for line i), word 3 the pending flags; any other word address reads 0 and ignores writes.
- R3: Trigger codes: 0 sets pending while the line is low, 1 while it is high, 2 on a falling edge, 4 on a rising edge, 6 on either edge; every other code never sets pending, and an edge mode ignores the opposite edge.
- R4: Parent output 0 is high when any of lines 0 to 3 is pending and unmasked; output 1 covers lines 4 to 11, output 2 lines 12 to 19, output 3 lines 20 to 27.
- R5: A mask bit of 1 keeps its line from every parent output and a 0 lets it through; masking does not stop the pending flag from being set or kept.
- R6: Writing a 1 to a bit of the pending register clears that flag; a 0 leaves it as it was.
- R7: In a level mode the flag is set again on every cycle the active level lasts, so a clear written while the level is held has no lasting effect.
- R8: When a detection and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R9: A level change driven before clock edge k is seen by the detector at edge k+1 and sets the pending flag at edge k+2; the flag reads 0 after edge k+1 and 1 after edge k+2.
- R10: The synchroniser and edge history reset to high, so a line held high through reset produces no event in any mode once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wakeIn | input | 28 | Asynchronous wakeup lines |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as a read request |
| parentIrq | output | 4 | Per-range interrupt requests |

## Verification
The bench aims at the single edge where a new event and a write-one clear coincide: a design where clear wins loses the edge event forever and the flag reads 0. It counts the exact edge at which a change first shows in the pending register, so a missing or extra synchroniser stage moves the flag one cycle and is caught. It probes the shared trigger field, the range boundaries between lines 3/4, 11/12 and 19/20, unused trigger codes and the upper bits of the second trigger register; a design that routed a line to the wrong parent, decoded one field per line or stored bits 31:24 would show a wrong output or a wrong readback. Level modes are checked by clearing while the level holds, where a design that treats levels as one-shot would read the flag as cleared.

// File: rtl/wkup_eint_pkg.sv
package wkup_eint_pkg;

  localparam int DATA_W         = 32;
  localparam int TRIG_W         = 4;
  localparam int LINES_PER_TRIG = 2;

  // Trigger field encodings; any other value disables detection.
  typedef enum logic [TRIG_W-1:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd4,
    TRIG_BOTH = 4'd6
  } trig_e;

  // Low two bits of the word address once the upper bits are zero.
  typedef enum logic [1:0] {
    REG_CFG_LO = 2'd0,
    REG_CFG_HI = 2'd1,
    REG_MASK   = 2'd2,
    REG_PEND   = 2'd3
  } reg_sel_e;

  // One-cycle strobes from bus decode to the register/detect datapath.
  typedef struct packed {
    logic              cfgLoWr;
    logic              cfgHiWr;
    logic              maskWr;
    logic              pendClr;
    logic [DATA_W-1:0] wdata;
  } strobe_t;

endpackage

// File: rtl/wkup_eint_detect.sv
module wkup_eint_detect
  import wkup_eint_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic [TRIG_W-1:0] trig,
  output logic              hit
);

  logic syncA;
  logic syncB;
  logic histQ;

  // Two-flop synchroniser plus one history flop; idle level is high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      histQ <= 1'b1;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      histQ <= syncB;
    end
  end

  always_comb begin
    case (trig)
      TRIG_LOW:  hit = !syncB;
      TRIG_HIGH: hit = syncB;
      TRIG_FALL: hit = histQ && !syncB;
      TRIG_RISE: hit = !histQ && syncB;
      TRIG_BOTH: hit = histQ ^ syncB;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/wkup_eint_busctl.sv
module wkup_eint_busctl
  import wkup_eint_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_LINES = 28
) (
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [DATA_W-1:0]    cfgLoView,
  input  logic [DATA_W-1:0]    cfgHiView,
  input  logic [NUM_LINES-1:0] maskView,
  input  logic [NUM_LINES-1:0] pendView,
  output strobe_t              strobes,
  output logic [DATA_W-1:0]    busRdata
);

  localparam int PAD_W = DATA_W - NUM_LINES;

  logic     inMap;
  reg_sel_e regSel;
  logic     doWrite;
  logic     doRead;

  assign inMap   = (busAddr[ADDR_W-1:2] == '0);
  assign regSel  = reg_sel_e'(busAddr[1:0]);
  assign doWrite = busSel && busWrite && inMap;
  assign doRead  = busSel && !busWrite && inMap;

  always_comb begin
    strobes.cfgLoWr = doWrite && (regSel == REG_CFG_LO);
    strobes.cfgHiWr = doWrite && (regSel == REG_CFG_HI);
    strobes.maskWr  = doWrite && (regSel == REG_MASK);
    strobes.pendClr = doWrite && (regSel == REG_PEND);
    strobes.wdata   = busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (doRead) begin
      case (regSel)
        REG_CFG_LO: busRdata = cfgLoView;
        REG_CFG_HI: busRdata = cfgHiView;
        REG_MASK:   busRdata = {{PAD_W{1'b0}}, maskView};
        REG_PEND:   busRdata = {{PAD_W{1'b0}}, pendView};
        default:    busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wkup_eint_datapath.sv
module wkup_eint_datapath
  import wkup_eint_pkg::*;
#(
  parameter int FIRST_GROUP = 4,
  parameter int GROUP_SIZE  = 8,
  parameter int NUM_PARENTS = 4,
  parameter int NUM_LINES   = FIRST_GROUP + GROUP_SIZE * (NUM_PARENTS - 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   wakeIn,
  input  strobe_t                strobes,
  output logic [DATA_W-1:0]      cfgLoView,
  output logic [DATA_W-1:0]      cfgHiView,
  output logic [NUM_LINES-1:0]   maskView,
  output logic [NUM_LINES-1:0]   pendView,
  output logic [NUM_PARENTS-1:0] parentIrq
);

  localparam int CFG_BITS = (NUM_LINES / LINES_PER_TRIG) * TRIG_W;
  localparam int HI_BITS  = CFG_BITS - DATA_W;

  logic [CFG_BITS-1:0]  cfgQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] hitVec;
  logic [NUM_LINES-1:0] clrVec;
  logic [NUM_LINES-1:0] liveVec;

  // Trigger fields: two registers, the upper one only partly populated.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      if (strobes.cfgLoWr) cfgQ[DATA_W-1:0] <= strobes.wdata;
      if (strobes.cfgHiWr) cfgQ[CFG_BITS-1:DATA_W] <= strobes.wdata[HI_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '1;
    else if (strobes.maskWr) maskQ <= strobes.wdata[NUM_LINES-1:0];
  end

  assign clrVec = strobes.pendClr ? strobes.wdata[NUM_LINES-1:0] : '0;

  // Set has priority over a same-edge write-one clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrVec) | hitVec;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    wkup_eint_detect u_det (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (wakeIn[i]),
      .trig   (cfgQ[(i / LINES_PER_TRIG) * TRIG_W +: TRIG_W]),
      .hit    (hitVec[i])
    );
  end

  assign liveVec = pendQ & ~maskQ;

  for (genvar g = 0; g < NUM_PARENTS; g++) begin : g_parent
    localparam int LO  = (g == 0) ? 0 : FIRST_GROUP + (g - 1) * GROUP_SIZE;
    localparam int WID = (g == 0) ? FIRST_GROUP : GROUP_SIZE;

    assign parentIrq[g] = |liveVec[LO +: WID];

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
      (&maskQ[LO +: WID]) |-> !parentIrq[g]);
  end

  assign cfgLoView = cfgQ[DATA_W-1:0];
  assign cfgHiView = {{(DATA_W - HI_BITS){1'b0}}, cfgQ[CFG_BITS-1:DATA_W]};
  assign maskView  = maskQ;
  assign pendView  = pendQ;

  // A flag only drops on an edge where software wrote a one to it.
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((~pendQ & $past(pendQ) & ~$past(clrVec)) == '0));

  // Every detection leaves its flag set, whatever was written that edge.
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((~pendQ & $past(hitVec)) == '0));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWr |=> (maskQ == $past(strobes.wdata[NUM_LINES-1:0])));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cfgLoWr |=> $stable(cfgQ[DATA_W-1:0]));

endmodule

// File: rtl/wkup_eint_ctrl.sv
module wkup_eint_ctrl
  import wkup_eint_pkg::*;
#(
  parameter int FIRST_GROUP = 4,
  parameter int GROUP_SIZE  = 8,
  parameter int NUM_PARENTS = 4,
  parameter int ADDR_W      = 4,
  localparam int NUM_LINES  = FIRST_GROUP + GROUP_SIZE * (NUM_PARENTS - 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LINES-1:0]   wakeIn,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic [NUM_PARENTS-1:0] parentIrq
);

  strobe_t              strobes;
  logic [DATA_W-1:0]    cfgLoView;
  logic [DATA_W-1:0]    cfgHiView;
  logic [NUM_LINES-1:0] maskView;
  logic [NUM_LINES-1:0] pendView;

  wkup_eint_busctl #(
    .ADDR_W    (ADDR_W),
    .NUM_LINES (NUM_LINES)
  ) u_busctl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .cfgLoView (cfgLoView),
    .cfgHiView (cfgHiView),
    .maskView  (maskView),
    .pendView  (pendView),
    .strobes   (strobes),
    .busRdata  (busRdata)
  );

  wkup_eint_datapath #(
    .FIRST_GROUP (FIRST_GROUP),
    .GROUP_SIZE  (GROUP_SIZE),
    .NUM_PARENTS (NUM_PARENTS),
    .NUM_LINES   (NUM_LINES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wakeIn    (wakeIn),
    .strobes   (strobes),
    .cfgLoView (cfgLoView),
    .cfgHiView (cfgHiView),
    .maskView  (maskView),
    .pendView  (pendView),
    .parentIrq (parentIrq)
  );

endmodule

// File: tb/wkup_eint_ctrl_tb_top.sv
`timescale 1ns/1ps
module wkup_eint_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] wakeIn = '1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  parentIrq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] rv;

  // Reference state computed from the requirements.
  logic [27:0] mS1, mS2, mPrev, mPend, mMask;
  logic [55:0] mCfg;

  always #2.5 clk = ~clk;

  wkup_eint_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .parentIrq(parentIrq)
  );

  function automatic logic detHit(logic [3:0] code, logic cur, logic prv);
    case (code)
      4'd0: return !cur;
      4'd1: return cur;
      4'd2: return prv && !cur;
      4'd4: return !prv && cur;
      4'd6: return prv ^ cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] expParent(logic [27:0] p, logic [27:0] m);
    logic [27:0] live = p & ~m;
    return {|live[27:20], |live[19:12], |live[11:4], |live[3:0]};
  endfunction

  function automatic logic [31:0] randCfg();
    logic [31:0] w;
    for (int f = 0; f < 8; f++) begin
      case ($urandom % 7)
        0: w[f*4 +: 4] = 4'd0;
        1: w[f*4 +: 4] = 4'd1;
        2: w[f*4 +: 4] = 4'd2;
        3: w[f*4 +: 4] = 4'd4;
        4: w[f*4 +: 4] = 4'd6;
        5: w[f*4 +: 4] = 4'd3;
        default: w[f*4 +: 4] = 4'($urandom);
      endcase
    end
    return w;
  endfunction

  always @(posedge clk) begin
    logic [27:0] hits;
    logic [27:0] clr;
    if (!rstN) begin
      mS1 = '1; mS2 = '1; mPrev = '1; mPend = '0; mMask = '1; mCfg = '0;
    end else begin
      for (int i = 0; i < 28; i++) hits[i] = detHit(mCfg[(i/2)*4 +: 4], mS2[i], mPrev[i]);
      clr = (busSel && busWrite && busAddr == 4'd3) ? busWdata[27:0] : '0;
      if (busSel && busWrite && busAddr == 4'd0) mCfg[31:0] = busWdata;
      if (busSel && busWrite && busAddr == 4'd1) mCfg[55:32] = busWdata[23:0];
      if (busSel && busWrite && busAddr == 4'd2) mMask = busWdata[27:0];
      mPend = (mPend & ~clr) | hits;
      mPrev = mS2; mS2 = mS1; mS1 = wakeIn;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state, read during reset
    idle(3);
    rd(4'd0, rv); chk("R1 cfg lo", rv, 32'h0);
    rd(4'd1, rv); chk("R1 cfg hi", rv, 32'h0);
    rd(4'd2, rv); chk("R1 mask", rv, 32'h0FFF_FFFF);
    rd(4'd3, rv); chk("R1 pend", rv, 32'h0);
    chk("R1 parents", 32'(parentIrq), 32'h0);
    @(negedge clk); rstN = 1'b1;
    idle(5);
    rd(4'd3, rv); chk("R10 no event after reset with lines high", rv, 32'h0);

    // R2 map, unused codes (R3)
    wr(4'd0, 32'h3535_3535);
    rd(4'd0, rv); chk("R2 cfg lo readback", rv, 32'h3535_3535);
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, rv); chk("R2 cfg hi upper bits zero", rv, 32'h00FF_FFFF);
    wr(4'd5, 32'h0);
    rd(4'd5, rv); chk("R2 unmapped reads zero", rv, 32'h0);
    rd(4'd0, rv); chk("R2 unmapped write ignored", rv, 32'h3535_3535);
    @(negedge clk); wakeIn = '0; idle(4); wakeIn = '1; idle(4);
    rd(4'd3, rv); chk("R3 unused codes never pend", rv, 32'h0);
    wr(4'd0, 32'h0); wr(4'd1, 32'h0);

    // R3 rising mode, R9 latency, R4 parent 0
    wr(4'd0, 32'h0000_0004);
    wr(4'd2, 32'h0FFF_FFFE);
    @(negedge clk); wakeIn[0] = 1'b0; idle(4);
    rd(4'd3, rv); chk("R3 rise ignores falling", rv, 32'h0);
    @(negedge clk); wakeIn[0] = 1'b1;
    rd(4'd3, rv); chk("R9 not set after edge k", rv, 32'h0);
    rd(4'd3, rv); chk("R9 not set after edge k+1", rv, 32'h0);
    rd(4'd3, rv); chk("R9 set after edge k+2", rv, 32'h1);
    chk("R4 parent 0 from line 0", 32'(parentIrq), 32'h1);

    // R6 write-one clear
    wr(4'd3, 32'h0);
    rd(4'd3, rv); chk("R6 zero write keeps flag", rv, 32'h1);
    wr(4'd3, 32'h1);
    rd(4'd3, rv); chk("R6 one write clears flag", rv, 32'h0);
    chk("R6 parent drops", 32'(parentIrq), 32'h0);

    // R8 event coincides with clear
    @(negedge clk); wakeIn[0] = 1'b0; idle(4);
    @(negedge clk); wakeIn[0] = 1'b1; idle(4);
    @(negedge clk); wakeIn[0] = 1'b0; idle(4);
    rd(4'd3, rv); chk("R8 setup flag set", rv, 32'h1);
    @(negedge clk); wakeIn[0] = 1'b1;
    @(negedge clk);
    wr(4'd3, 32'h1);
    rd(4'd3, rv); chk("R8 set wins over clear", rv, 32'h1);

    // R5 masked line keeps flag, output blocked
    wr(4'd2, 32'h0FFF_FFFF);
    rd(4'd3, rv); chk("R5 pending kept while masked", rv, 32'h1);
    chk("R5 masked line blocked", 32'(parentIrq), 32'h0);
    wr(4'd3, 32'h1);

    // R7 high level on lines 2,3 sharing one field (R2)
    wr(4'd0, 32'h0000_0010);
    @(negedge clk); wakeIn[2] = 1'b1; wakeIn[3] = 1'b1; idle(4);
    rd(4'd3, rv); chk("R7 level sets both lines of shared field", rv & 32'hC, 32'hC);
    wr(4'd3, 32'hC);
    rd(4'd3, rv); chk("R7 clear under held level has no effect", rv & 32'hC, 32'hC);
    @(negedge clk); wakeIn[2] = 1'b0; wakeIn[3] = 1'b0; idle(4);
    wr(4'd3, 32'hC);
    rd(4'd3, rv); chk("R7 clear sticks once level gone", rv & 32'hC, 32'h0);
    @(negedge clk); wakeIn = '1;
    wr(4'd0, 32'h0); idle(4); wr(4'd3, 32'h0FFF_FFFF);

    // R3 both edges on line 20, R4 parent 3
    wr(4'd1, 32'h0000_0600);
    wr(4'd2, ~(32'h1 << 20) & 32'h0FFF_FFFF);
    @(negedge clk); wakeIn[20] = 1'b0; idle(4);
    rd(4'd3, rv); chk("R3 both mode falling", rv, 32'h0010_0000);
    chk("R4 line 20 to parent 3", 32'(parentIrq), 32'h8);
    wr(4'd3, 32'h0010_0000);
    @(negedge clk); wakeIn[20] = 1'b1; idle(4);
    rd(4'd3, rv); chk("R3 both mode rising", rv, 32'h0010_0000);
    wr(4'd3, 32'h0010_0000); wr(4'd1, 32'h0);

    // R3 falling on line 12, R4 parent 2
    wr(4'd0, 32'h0200_0000);
    wr(4'd2, ~(32'h1 << 12) & 32'h0FFF_FFFF);
    @(negedge clk); wakeIn[12] = 1'b0; idle(4);
    rd(4'd3, rv); chk("R3 falling mode", rv, 32'h0000_1000);
    chk("R4 line 12 to parent 2", 32'(parentIrq), 32'h4);
    wr(4'd3, 32'h0000_1000);
    @(negedge clk); wakeIn[12] = 1'b1; idle(4);
    rd(4'd3, rv); chk("R3 fall ignores rising", rv, 32'h0);
    wr(4'd0, 32'h0);

    // R3 low level on line 11, R4 parent 1
    wr(4'd2, ~(32'h1 << 11) & 32'h0FFF_FFFF);
    @(negedge clk); wakeIn[11] = 1'b0; idle(4);
    rd(4'd3, rv); chk("R3 low level", rv, 32'h0000_0800);
    chk("R4 line 11 to parent 1", 32'(parentIrq), 32'h2);
    @(negedge clk); wakeIn[11] = 1'b1; idle(4);
    wr(4'd3, 32'h0FFF_FFFF);
    rd(4'd3, rv); chk("R6 full clear", rv, 32'h0);

    // Random phase against the reference model (R3 R4 R5 R6 R8)
    for (int c = 0; c < 4000; c++) begin
      int op;
      @(negedge clk);
      if ($urandom % 6 == 0) wakeIn[$urandom % 28] ^= 1'b1;
      op = $urandom % 16;
      busSel = 1'b1;
      busWrite = (op < 6);
      busAddr = 4'd3;
      case (op)
        0: begin busAddr = 4'd0; busWdata = randCfg(); end
        1: begin busAddr = 4'd1; busWdata = randCfg(); end
        2: begin busAddr = 4'd2; busWdata = $urandom; end
        3, 4: begin busAddr = 4'd3; busWdata = $urandom; end
        5: begin busAddr = 4'(4 + $urandom % 12); busWdata = $urandom; end
        default: busWdata = '0;
      endcase
      #1;
      chk("R4 random parent outputs", 32'(parentIrq), 32'(expParent(mPend, mMask)));
      if (!busWrite) chk("R5 random pending readback", busRdata, {4'h0, mPend});
    end
    @(negedge clk); busSel = 1'b0; busWrite = 1'b0;
    finishRun();
  end

endmodule